// File: doc/BRIEF.md
# Threshold Limiter Gain Envelope

This block computes the gain reduction for one limiter. It takes one level sample per strobe, in dB relative to full scale, and keeps a single attenuation value in dB. Every channel assigned to this limiter uses that one value. A separate multiplier applies the value to each channel. Level detection, the dB conversion and the gain multiplier sit outside this block.

When the level rises above the attack threshold, the reduction grows by a fixed per-sample step. The step is chosen by an attack rate code. When the level falls below the release threshold, the reduction shrinks by a release step. It stops at zero, so the gain never rises past unity. When the level lies between the two thresholds, the reduction is held.

The attack threshold comes from a 4-bit code, or from a 7-bit fine field when the fine override is enabled. The release threshold is set as an offset below the attack threshold. Rates are given in dB/ms and converted to per-sample steps for a 96 kHz sample rate. Internally the envelope keeps 8 fraction bits below the 1/256 dB output unit.

Top module: `lim_gain_env`

## Requirements
- R1: While reset is asserted, and after it is released, `gain_red` is 0 until the first sample strobe.
- R2: With `ext_thr_en`=0, the attack threshold is (-12 + 2·`atk_thr_code`) dB, which is -3072 + 512·code in 1/256 dB. A strobed `level_db` strictly above it raises the reduction by the attack step.
- R3: With `ext_thr_en`=1, the attack threshold is -12 dB + 0.125 dB·`ext_thr_val`, which is -3072 + 32·val, capped at 0. In this case `atk_thr_code` has no effect.
- R4: The attack step, in 1/65536 dB per sample, is 308·(7−c) for codes c=0..6. For c≥7 it is 308 shifted right by (c−6), with a minimum of 1.
- R5: A strobed level strictly below the release threshold lowers the reduction by the release step, in 1/65536 dB per sample. The step is 349 for code 0, 94 for code 1, and 94 shifted right by (c−1), with a minimum of 1, for codes c≥2.
- R6: Release never takes the reduction below 0, so the gain never exceeds unity.
- R7: A strobed level between the release threshold and the attack threshold, both ends included, leaves the reduction unchanged.
- R8: The reduction saturates at `MAX_RED` (default 12288, which is 48 dB) and never wraps.
- R9: The envelope changes only on clock edges where `smp_vld` is 1.
- R10: The release threshold is the attack threshold minus `rel_thr_code` dB, which is `rel_thr_code`·256 in 1/256 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | Level sample strobe |
| level_db | input | 16 | Signed level, 1/256 dB relative to full scale |
| atk_thr_code | input | 4 | Attack threshold code |
| rel_thr_code | input | 4 | Release threshold offset below attack, in dB |
| atk_rate_code | input | 4 | Attack rate code |
| rel_rate_code | input | 4 | Release rate code |
| ext_thr_en | input | 1 | Selects the fine attack threshold |
| ext_thr_val | input | 7 | Fine attack threshold, 0.125 dB steps from -12 dB |
| gain_red | output | 16 | Gain reduction, 1/256 dB, unsigned |

## Verification
Each envelope update shows on `gain_red` one clock after the rising edge that samples `smp_vld`. The bench drives a sample on a falling edge and compares on the next falling edge, where the registered value has settled. After `rst_n` rises, the internal reset synchronizer needs two edges, so the bench waits three cycles before the first strobe. Checks on idle cycles confirm that `gain_red` keeps its value when no strobe is present.

// File: rtl/lim_env_pkg.sv
package lim_env_pkg;
  localparam int STEP_W = 12;

  // attack step in 1/65536 dB per sample at 96 kHz
  function automatic logic [STEP_W-1:0] atk_step(input logic [3:0] code);
    int v;
    if (code <= 4'd6) v = 308 * (7 - int'(code));
    else              v = 308 >> (int'(code) - 6);
    if (v < 1) v = 1;
    return STEP_W'(v);
  endfunction

  // release step in 1/65536 dB per sample at 96 kHz
  function automatic logic [STEP_W-1:0] rel_step(input logic [3:0] code);
    int v;
    if (code == 4'd0) v = 349;
    else              v = 94 >> (int'(code) - 1);
    if (v < 1) v = 1;
    return STEP_W'(v);
  endfunction

  typedef enum logic [1:0] {ENV_HOLD, ENV_ATTACK, ENV_RELEASE} env_dir_e;
endpackage

// File: rtl/lim_thr_decode.sv
module lim_thr_decode #(
  parameter int LVL_W = 16
) (
  input  logic [3:0]              atk_thr_code,
  input  logic [3:0]              rel_thr_code,
  input  logic                    ext_thr_en,
  input  logic [6:0]              ext_thr_val,
  output logic signed [LVL_W-1:0] atk_thr,
  output logic signed [LVL_W-1:0] rel_thr
);
  localparam int BASE_THR = -3072;  // -12 dB in 1/256 dB
  localparam int CODE_STEP = 512;   // 2 dB
  localparam int FINE_STEP = 32;    // 0.125 dB
  localparam int REL_STEP = 256;    // 1 dB

  int atk_v;

  always_comb begin
    if (ext_thr_en) begin
      atk_v = BASE_THR + FINE_STEP * int'(ext_thr_val);
      if (atk_v > 0) atk_v = 0;
    end else begin
      atk_v = BASE_THR + CODE_STEP * int'(atk_thr_code);
    end
    atk_thr = LVL_W'(atk_v);
    rel_thr = LVL_W'(atk_v - REL_STEP * int'(rel_thr_code));
  end
endmodule

// File: rtl/lim_rate_decode.sv
module lim_rate_decode
  import lim_env_pkg::*;
(
  input  logic [3:0]        atk_rate_code,
  input  logic [3:0]        rel_rate_code,
  output logic [STEP_W-1:0] atk_inc,
  output logic [STEP_W-1:0] rel_dec
);
  always_comb begin
    atk_inc = atk_step(atk_rate_code);
    rel_dec = rel_step(rel_rate_code);
  end
endmodule

// File: rtl/lim_env_core.sv
module lim_env_core
  import lim_env_pkg::*;
#(
  parameter int LVL_W   = 16,
  parameter int RED_W   = 16,
  parameter int FRAC_W  = 8,
  parameter int MAX_RED = 12288
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [LVL_W-1:0] level_db,
  input  logic signed [LVL_W-1:0] atk_thr,
  input  logic signed [LVL_W-1:0] rel_thr,
  input  logic [STEP_W-1:0]       atk_inc,
  input  logic [STEP_W-1:0]       rel_dec,
  output logic [RED_W-1:0]        gain_red
);
  localparam int ACC_W = RED_W + FRAC_W;
  localparam logic [ACC_W:0] ACC_CAP = (ACC_W+1)'(MAX_RED) << FRAC_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;
  logic [ACC_W:0]   acc_sum;
  env_dir_e         dir;

  always_comb begin
    if (level_db > atk_thr)      dir = ENV_ATTACK;
    else if (level_db < rel_thr) dir = ENV_RELEASE;
    else                         dir = ENV_HOLD;
  end

  always_comb begin
    acc_en  = smp_vld;
    acc_sum = {1'b0, acc_q} + (ACC_W+1)'(atk_inc);
    unique case (dir)
      ENV_ATTACK:  acc_d = (acc_sum > ACC_CAP) ? ACC_CAP[ACC_W-1:0] : acc_sum[ACC_W-1:0];
      ENV_RELEASE: acc_d = (acc_q > ACC_W'(rel_dec)) ? acc_q - ACC_W'(rel_dec) : '0;
      default:     acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign gain_red = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/lim_gain_env.sv
module lim_gain_env
  import lim_env_pkg::*;
#(
  parameter int LVL_W   = 16,
  parameter int RED_W   = 16,
  parameter int FRAC_W  = 8,
  parameter int MAX_RED = 12288,
  parameter int SYNC_N  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [LVL_W-1:0] level_db,
  input  logic [3:0]              atk_thr_code,
  input  logic [3:0]              rel_thr_code,
  input  logic [3:0]              atk_rate_code,
  input  logic [3:0]              rel_rate_code,
  input  logic                    ext_thr_en,
  input  logic [6:0]              ext_thr_val,
  output logic [RED_W-1:0]        gain_red
);
  logic [SYNC_N-1:0]       rst_sync_q;
  logic                    rst_q_n;
  logic signed [LVL_W-1:0] atk_thr, rel_thr;
  logic [STEP_W-1:0]       atk_inc, rel_dec;

  // asynchronous assert, synchronous release
  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_q_n = rst_sync_q[SYNC_N-1];

  lim_thr_decode #(.LVL_W(LVL_W)) thr_i (
    .atk_thr_code(atk_thr_code),
    .rel_thr_code(rel_thr_code),
    .ext_thr_en  (ext_thr_en),
    .ext_thr_val (ext_thr_val),
    .atk_thr     (atk_thr),
    .rel_thr     (rel_thr)
  );

  lim_rate_decode rate_i (
    .atk_rate_code(atk_rate_code),
    .rel_rate_code(rel_rate_code),
    .atk_inc      (atk_inc),
    .rel_dec      (rel_dec)
  );

  lim_env_core #(
    .LVL_W(LVL_W), .RED_W(RED_W), .FRAC_W(FRAC_W), .MAX_RED(MAX_RED)
  ) core_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .smp_vld (smp_vld),
    .level_db(level_db),
    .atk_thr (atk_thr),
    .rel_thr (rel_thr),
    .atk_inc (atk_inc),
    .rel_dec (rel_dec),
    .gain_red(gain_red)
  );
endmodule

// File: rtl/lim_gain_env_chk.sv
module lim_gain_env_chk #(
  parameter int LVL_W   = 16,
  parameter int RED_W   = 16,
  parameter int MAX_RED = 12288
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic signed [LVL_W-1:0] level_db,
  input logic signed [LVL_W-1:0] atk_thr,
  input logic signed [LVL_W-1:0] rel_thr,
  input logic [RED_W-1:0]        gain_red
);
  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gain_red <= RED_W'(MAX_RED));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(gain_red));

  p_attack_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && level_db > atk_thr) |=> gain_red >= $past(gain_red));

  p_release_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && level_db < rel_thr) |=> gain_red <= $past(gain_red));

  p_hold_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && level_db <= atk_thr && level_db >= rel_thr) |=> $stable(gain_red));
endmodule

bind lim_gain_env lim_gain_env_chk #(
  .LVL_W(LVL_W), .RED_W(RED_W), .MAX_RED(MAX_RED)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .smp_vld (smp_vld),
  .level_db(level_db),
  .atk_thr (atk_thr),
  .rel_thr (rel_thr),
  .gain_red(gain_red)
);

// File: tb/lim_gain_env_tb_top.sv
module lim_gain_env_tb_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_vld = 1'b0;
  logic signed [15:0] level_db = '0;
  logic [3:0]         atk_thr_code = '0, rel_thr_code = '0;
  logic [3:0]         atk_rate_code = '0, rel_rate_code = '0;
  logic               ext_thr_en = 1'b0;
  logic [6:0]         ext_thr_val = '0;
  logic [15:0]        gain_red;

  int checks = 0;
  int errors = 0;
  int m_acc = 0;
  bit done = 1'b0;
  localparam int CAP = 12288 * 256;

  always #10 clk = ~clk;

  lim_gain_env dut_i (.*);

  function automatic int f_atk(input int c);
    int v = (c <= 6) ? 308 * (7 - c) : (308 >> (c - 6));
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int f_rel(input int c);
    int v = (c == 0) ? 349 : (94 >> (c - 1));
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int f_athr(input bit ee, input int ev, input int ac);
    int t;
    if (ee) begin t = -3072 + 32 * ev; if (t > 0) t = 0; end
    else t = -3072 + 512 * ac;
    return t;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: gain_red=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_vld = 1'b0; m_acc = 0;
    repeat (2) @(negedge clk);
    check("R1", gain_red, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", gain_red, 0);
  endtask

  // one strobed sample; checked at the following falling edge
  task automatic sample(input int lvl, input int ac, input int rc, input int ar,
                        input int rr, input bit ee, input int ev, input bit vld);
    int at, rt;
    string tag;
    level_db = 16'(lvl); atk_thr_code = 4'(ac); rel_thr_code = 4'(rc);
    atk_rate_code = 4'(ar); rel_rate_code = 4'(rr);
    ext_thr_en = ee; ext_thr_val = 7'(ev); smp_vld = vld;
    at = f_athr(ee, ev, ac);
    rt = at - 256 * rc;
    if (!vld) tag = "R9";
    else if (lvl > at) begin
      m_acc += f_atk(ar);
      if (m_acc >= CAP) begin m_acc = CAP; tag = "R8"; end
      else tag = ee ? "R3" : "R2";
    end else if (lvl < rt) begin
      m_acc -= f_rel(rr);
      if (m_acc <= 0) begin m_acc = 0; tag = "R6"; end
      else tag = "R5";
    end else tag = (rc != 0) ? "R10" : "R7";
    @(negedge clk);
    check(tag, gain_red, m_acc >> 8);
    smp_vld = 1'b0;
  endtask

  initial begin
    do_reset();
    // R2: one LSB above the code threshold attacks
    sample(-3071, 0, 0, 0, 0, 0, 0, 1);
    check("R2", gain_red, 2156 >> 8);
    // R7: exactly at the threshold holds
    sample(-3072, 0, 0, 0, 0, 0, 0, 1);
    check("R7", gain_red, 8);
    // R10: release threshold 2 dB below attack
    sample(-3500, 0, 2, 0, 0, 0, 0, 1);
    check("R10", gain_red, 8);
    sample(-3584, 0, 2, 0, 0, 0, 0, 1);
    check("R10", gain_red, 8);
    sample(-3585, 0, 2, 0, 0, 0, 0, 1);
    check("R5", gain_red, (2156 - 349) >> 8);
    // R3: fine threshold overrides code 15
    sample(-3000, 15, 0, 0, 0, 1, 0, 1);
    sample(1, 15, 0, 0, 0, 1, 127, 1);
    sample(0, 0, 0, 0, 0, 1, 127, 1);
    check("R3", gain_red, m_acc >> 8);
    // R9: idle cycles with loud level
    for (int i = 0; i < 4; i++) sample(9000, 0, 0, 0, 0, 0, 0, 0);
    check("R9", gain_red, m_acc >> 8);

    // R4: 256 attack samples give exactly the step; R5: 256 release samples
    for (int c = 0; c < 16; c++) begin
      do_reset();
      for (int i = 0; i < 256; i++) sample(5000, 0, 0, c, 0, 0, 0, 1);
      check("R4", gain_red, f_atk(c));
    end
    for (int c = 0; c < 16; c++) begin
      do_reset();
      for (int i = 0; i < 256; i++) sample(5000, 0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 256; i++) sample(-9000, 0, 0, 0, c, 0, 0, 1);
      check("R5", gain_red, 2156 - f_rel(c));
    end

    // R8: saturation
    do_reset();
    for (int i = 0; i < 1500; i++) sample(20000, 0, 0, 0, 0, 0, 0, 1);
    check("R8", gain_red, 12288);
    // R6: floor at zero
    for (int i = 0; i < 9100; i++) sample(-20000, 0, 0, 0, 0, 0, 0, 1);
    check("R6", gain_red, 0);

    // random mix
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
    end
    for (int i = 0; i < 4000; i++) begin
      sample(int'($urandom_range(14000)) - 9000, int'($urandom_range(15)),
             int'($urandom_range(15)), int'($urandom_range(15)),
             int'($urandom_range(15)), ($urandom_range(3) == 0),
             int'($urandom_range(127)), ($urandom_range(4) != 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule